// File: doc/BRIEF.md
# Two-Bit Condition Code and Branch Decision Unit

This unit keeps a two-bit condition code and uses it to decide conditional branches. Each cycle it runs one arithmetic operation on two 32-bit operands: add, subtract or compare, in a signed or a logical (unsigned) form. It returns the arithmetic result on the same cycle. When the set enable is high, the operation's two-bit code is written into the code register at the next rising clock edge. The signed and logical forms give the four code values different meanings.

A branch request carries a four-bit one-hot-per-code mask. The unit reports taken in the same cycle when the mask bit for the current code is 1. A mask of all ones therefore makes an unconditional branch, and a mask of all zeros makes a no-op. If a code-setting operation and a branch are presented in the same cycle, the branch is judged against the freshly computed code and not the stored one.

The operation, operand, mask and branch inputs are sampled each cycle with no handshake. The unit accepts one operation and one branch per cycle and never stalls. There is therefore no back-pressure path and no ready signal.

Top module: `cc_branch_unit`

## Requirements
- R1: A synchronous active-high reset clears the stored code to 0, and the `cc` output shows 0 on the cycle after reset.
- R2: The stored code changes only on a rising edge where `set_en` is 1 and the operation is a code-setting one (op 0 to 5). Otherwise it is held. Op codes 6 and 7 are pass operations that never change the code.
- R3: Signed add (op 0) and signed subtract (op 1) produce code 3 on two's-complement overflow. Otherwise they produce code 0 for a zero result, code 1 for a negative result and code 2 for a positive result.
- R4: Logical add (op 3) produces code {carry, result nonzero}: 0 for zero with no carry, 1 for nonzero with no carry, 2 for zero with carry and 3 for nonzero with carry.
- R5: Logical subtract (op 4) uses the same rule as R4, with carry meaning that no borrow occurred (first operand greater than or equal to the second as magnitudes).
- R6: Signed compare (op 2) produces code 0 when the operands are equal, 1 when the first is lower and 2 when it is higher, ordering two's-complement values. It never produces code 3.
- R7: Logical compare (op 5) produces codes 0, 1 and 2 with the same meanings as R6, ordering unsigned magnitudes. It never produces code 3.
- R8: `br_taken` is 1 in the same cycle when `br_valid` is 1 and mask bit (3 − code) is 1. Bit 3 selects code 0, bit 2 selects code 1, bit 1 selects code 2 and bit 0 selects code 3.
- R9: With `br_valid` at 1, a mask of 1111 always gives taken and a mask of 0000 never does, whatever the code.
- R10: When `set_en` is 1 with a code-setting op in the same cycle as a branch, the branch is decided on the newly computed code.
- R11: With `br_valid` at 0, `br_taken` is 0.
- R12: `result` is the 32-bit sum for ops 0 and 3, the difference a − b for ops 1, 2, 4 and 5, and operand a for ops 6 and 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_sel | input | 3 | Operation: 0 add, 1 sub, 2 cmp, 3 add logical, 4 sub logical, 5 cmp logical, 6/7 pass |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| set_en | input | 1 | Write the operation's code at the next edge |
| br_valid | input | 1 | A branch is being decided this cycle |
| br_mask | input | 4 | Taken condition, bit 3 selects code 0 down to bit 0 selecting code 3 |
| result | output | 32 | Arithmetic result of the current operation |
| cc | output | 2 | Stored condition code |
| br_taken | output | 1 | Branch decision for this cycle |

## Verification
Setting the code and deciding a branch can fall in the same cycle, and the bypass decides which code the branch sees. The vector walk provokes this on every entry. It raises `set_en` and `br_valid` together and uses a mask whose only set bit selects the code that the operation is expected to produce. This is judged as a same-cycle taken while the stored code still holds the previous entry's value. Directed steps then lower `set_en` and confirm that the branch falls back to the stored code.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int CODE_W = 2;
  localparam int MASK_W = 1 << CODE_W;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_CMP   = 3'd2,
    OP_ADDL  = 3'd3,
    OP_SUBL  = 3'd4,
    OP_CMPL  = 3'd5,
    OP_PASS0 = 3'd6,
    OP_PASS1 = 3'd7
  } op_e;

  typedef logic [CODE_W-1:0] code_t;

  localparam code_t CC_ZERO = 2'd0;
  localparam code_t CC_ONE  = 2'd1;
  localparam code_t CC_TWO  = 2'd2;
  localparam code_t CC_OVF  = 2'd3;
endpackage

// File: rtl/cc_alu.sv
module cc_alu
  import cc_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  op_e              op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] result,
  output code_t            code,
  output logic             sets_code
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0]   sum_ext;
  logic [WIDTH:0]   dif_ext;
  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] dif;
  logic             add_carry;
  logic             sub_nob;
  logic             add_ovf;
  logic             sub_ovf;
  logic             s_lt;
  logic             u_lt;
  logic             eq;

  assign sum_ext   = {1'b0, a} + {1'b0, b};
  assign dif_ext   = {1'b0, a} + {1'b0, ~b} + {{WIDTH{1'b0}}, 1'b1};
  assign sum       = sum_ext[WIDTH-1:0];
  assign dif       = dif_ext[WIDTH-1:0];
  assign add_carry = sum_ext[WIDTH];
  assign sub_nob   = dif_ext[WIDTH];

  assign add_ovf = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
  assign sub_ovf = (a[MSB] != b[MSB]) && (dif[MSB] != a[MSB]);

  assign eq   = (a == b);
  assign u_lt = ~sub_nob;
  assign s_lt = (a[MSB] ^ b[MSB]) ? a[MSB] : dif[MSB];

  function automatic code_t signed_code(input logic ovf, input logic [WIDTH-1:0] v);
    if (ovf)           return CC_OVF;
    else if (v == '0)  return CC_ZERO;
    else if (v[MSB])   return CC_ONE;
    else               return CC_TWO;
  endfunction

  function automatic code_t order_code(input logic is_eq, input logic is_lt);
    if (is_eq)      return CC_ZERO;
    else if (is_lt) return CC_ONE;
    else            return CC_TWO;
  endfunction

  always_comb begin
    result    = a;
    code      = CC_ZERO;
    sets_code = 1'b1;
    unique case (op)
      OP_ADD: begin
        result = sum;
        code   = signed_code(add_ovf, sum);
      end
      OP_SUB: begin
        result = dif;
        code   = signed_code(sub_ovf, dif);
      end
      OP_CMP: begin
        result = dif;
        code   = order_code(eq, s_lt);
      end
      OP_ADDL: begin
        result = sum;
        code   = {add_carry, |sum};
      end
      OP_SUBL: begin
        result = dif;
        code   = {sub_nob, |dif};
      end
      OP_CMPL: begin
        result = dif;
        code   = order_code(eq, u_lt);
      end
      default: begin
        result    = a;
        code      = CC_ZERO;
        sets_code = 1'b0;
      end
    endcase
  end

  // R6 / R7: compares never yield code 3
  a_r6_cmp_no_code3: assert property (@(posedge clk) disable iff (rst)
    (op == OP_CMP || op == OP_CMPL) |-> code != CC_OVF);

  // R4: a logical add with zero operands cannot report a carry
  a_r4_zero_no_carry: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ADDL && a == '0 && b == '0) |-> code == CC_ZERO);

  // R12: pass operations return operand a and do not set the code
  a_r12_pass_through: assert property (@(posedge clk) disable iff (rst)
    (op == OP_PASS0 || op == OP_PASS1) |-> (result == a && !sets_code));
endmodule

// File: rtl/cc_reg.sv
module cc_reg
  import cc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  wr_en,
  input  code_t wr_code,
  output code_t code_q
);
  always_ff @(posedge clk) begin
    if (rst)        code_q <= CC_ZERO;
    else if (wr_en) code_q <= wr_code;
  end

  // R1: reset clears the stored code
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> code_q == CC_ZERO);

  // R2: no write, no change
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(code_q));

  // R2: a write lands on the next edge
  a_r2_write: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> code_q == $past(wr_code));
endmodule

// File: rtl/cc_branch_eval.sv
module cc_branch_eval
  import cc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  code_t             stored_code,
  input  code_t             fresh_code,
  input  logic              fresh_valid,
  input  logic              br_valid,
  input  logic [MASK_W-1:0] mask,
  output logic              taken
);
  code_t             eff_code;
  logic [MASK_W-1:0] hit;

  // R10: a same-cycle update is bypassed to the branch
  assign eff_code = fresh_valid ? fresh_code : stored_code;

  // R8: mask bit (MASK_W-1-i) selects code value i
  for (genvar i = 0; i < MASK_W; i++) begin : g_hit
    assign hit[i] = mask[MASK_W-1-i] && (eff_code == code_t'(i));
  end

  assign taken = br_valid && (|hit);

  // R9: an all-ones mask always branches
  a_r9_all_ones: assert property (@(posedge clk) disable iff (rst)
    (br_valid && mask == '1) |-> taken);

  // R9: an all-zeros mask never branches
  a_r9_all_zeros: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |-> !taken);

  // R11: no request, no branch
  a_r11_idle: assert property (@(posedge clk) disable iff (rst)
    !br_valid |-> !taken);

  // R8: at most one code can be hit
  a_r8_single_hit: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit));
endmodule

// File: rtl/cc_branch_unit.sv
module cc_branch_unit
  import cc_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       op_sel,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic             set_en,
  input  logic             br_valid,
  input  logic [3:0]       br_mask,
  output logic [WIDTH-1:0] result,
  output logic [1:0]       cc,
  output logic             br_taken
);
  op_e   op;
  code_t alu_code;
  logic  alu_sets;
  logic  write_code;
  code_t code_q;

  assign op         = op_e'(op_sel);
  assign write_code = set_en && alu_sets;

  cc_alu #(.WIDTH(WIDTH)) alu_i (
    .clk       (clk),
    .rst       (rst),
    .op        (op),
    .a         (opnd_a),
    .b         (opnd_b),
    .result    (result),
    .code      (alu_code),
    .sets_code (alu_sets)
  );

  cc_reg reg_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (write_code),
    .wr_code (alu_code),
    .code_q  (code_q)
  );

  cc_branch_eval br_i (
    .clk         (clk),
    .rst         (rst),
    .stored_code (code_q),
    .fresh_code  (alu_code),
    .fresh_valid (write_code),
    .br_valid    (br_valid),
    .mask        (br_mask),
    .taken       (br_taken)
  );

  assign cc = code_q;

  // R2: pass ops leave the stored code untouched even with set_en
  a_r2_pass_holds: assert property (@(posedge clk) disable iff (rst)
    (op_sel[2:1] == 2'b11) |=> $stable(cc));
endmodule

// File: tb/cc_branch_unit_tb_top.sv
module cc_branch_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  op_sel;
  logic [31:0] opnd_a, opnd_b;
  logic        set_en, br_valid;
  logic [3:0]  br_mask;
  logic [31:0] result;
  logic [1:0]  cc;
  logic        br_taken;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  cc_branch_unit dut_i (
    .clk(clk), .rst(rst), .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .set_en(set_en), .br_valid(br_valid), .br_mask(br_mask),
    .result(result), .cc(cc), .br_taken(br_taken)
  );

  // {op, a, b, expected result, expected code}
  localparam int NV = 19;
  localparam logic [100:0] VECS [NV] = '{
    {3'd0, 32'h00000005, 32'hFFFFFFFB, 32'h00000000, 2'd0}, // R3 zero
    {3'd0, 32'h00000001, 32'hFFFFFFFD, 32'hFFFFFFFE, 2'd1}, // R3 negative
    {3'd0, 32'h00000007, 32'h00000008, 32'h0000000F, 2'd2}, // R3 positive
    {3'd0, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 2'd3}, // R3 overflow
    {3'd1, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 2'd3}, // R3 sub overflow
    {3'd1, 32'h00000003, 32'h00000005, 32'hFFFFFFFE, 2'd1}, // R3 sub negative
    {3'd3, 32'h00000000, 32'h00000000, 32'h00000000, 2'd0}, // R4
    {3'd3, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 2'd2}, // R4
    {3'd3, 32'hFFFFFFFF, 32'h00000002, 32'h00000001, 2'd3}, // R4
    {3'd3, 32'h00000001, 32'h00000002, 32'h00000003, 2'd1}, // R4
    {3'd4, 32'h00000005, 32'h00000005, 32'h00000000, 2'd2}, // R5
    {3'd4, 32'h00000003, 32'h00000005, 32'hFFFFFFFE, 2'd1}, // R5
    {3'd4, 32'h00000009, 32'h00000004, 32'h00000005, 2'd3}, // R5
    {3'd2, 32'hFFFFFFFF, 32'h00000001, 32'hFFFFFFFE, 2'd1}, // R6
    {3'd2, 32'h00000007, 32'h00000007, 32'h00000000, 2'd0}, // R6
    {3'd2, 32'h00000001, 32'hFFFFFFFF, 32'h00000002, 2'd2}, // R6
    {3'd2, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 2'd1}, // R6 overflowing diff
    {3'd5, 32'hFFFFFFFF, 32'h00000001, 32'hFFFFFFFE, 2'd2}, // R7
    {3'd5, 32'h00000001, 32'hFFFFFFFF, 32'h00000002, 2'd1}  // R7
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic s, input logic v, input logic [3:0] m);
    op_sel = o; opnd_a = a; opnd_b = b; set_en = s; br_valid = v; br_mask = m;
  endtask

  initial begin
    #1500000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1;
    drive(3'd6, 32'h0, 32'h0, 1'b0, 1'b0, 4'h0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1: code 0 after reset, branch on code 0 taken
    drive(3'd6, 32'h0, 32'h0, 1'b0, 1'b1, 4'b1000);
    #2;
    check("R1 cc", {30'd0, cc}, 32'd0);
    check("R1 taken code0", {31'd0, br_taken}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      logic [2:0]  vo; logic [31:0] va, vb, vr; logic [1:0] vc;
      {vo, va, vb, vr, vc} = VECS[i];
      @(negedge clk);
      drive(vo, va, vb, 1'b1, 1'b1, 4'b1000 >> vc);
      #2;
      check($sformatf("R12 result v%0d", i), result, vr);
      check($sformatf("R10 bypass taken v%0d", i), {31'd0, br_taken}, 32'd1);
      @(negedge clk);
      set_en = 1'b0;
      #1;
      check($sformatf("R3-7 code v%0d (R2)", i), {30'd0, cc}, {30'd0, vc});
    end

    // establish code 2 (signed positive)
    @(negedge clk) drive(3'd0, 32'd7, 32'd8, 1'b1, 1'b0, 4'h0);
    @(negedge clk) drive(3'd0, 32'd7, 32'd8, 1'b0, 1'b1, 4'b0010);
    #2 check("R8 mask bit1 selects code2", {31'd0, br_taken}, 32'd1);
    br_mask = 4'b1101; #1 check("R8 other bits miss", {31'd0, br_taken}, 32'd0);
    br_mask = 4'b1111; #1 check("R9 all ones", {31'd0, br_taken}, 32'd1);
    br_mask = 4'b0000; #1 check("R9 all zeros", {31'd0, br_taken}, 32'd0);
    br_valid = 1'b0; br_mask = 4'b1111;
    #1 check("R11 no valid", {31'd0, br_taken}, 32'd0);
    // R10 inverse: without set_en the stored code is used
    drive(3'd0, 32'h7FFFFFFF, 32'h1, 1'b0, 1'b1, 4'b0001);
    #1 check("R10 no bypass when set_en low", {31'd0, br_taken}, 32'd0);
    @(negedge clk) #1 check("R2 set_en low holds", {30'd0, cc}, 32'd2);
    // pass op with set_en high
    drive(3'd6, 32'hCAFE1234, 32'h1, 1'b1, 1'b1, 4'b0010);
    #1 check("R12 pass result", result, 32'hCAFE1234);
    check("R2 pass uses stored code", {31'd0, br_taken}, 32'd1);
    @(negedge clk) op_sel = 3'd7;
    #1 check("R2 pass keeps code", {30'd0, cc}, 32'd2);
    @(negedge clk) #1 check("R2 pass7 keeps code", {30'd0, cc}, 32'd2);
    // mid-run reset
    drive(3'd6, 32'h0, 32'h0, 1'b0, 1'b0, 4'h0);
    rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    #1 check("R1 mid-run reset", {30'd0, cc}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule